// File: doc/BRIEF.md
# DMA channel transfer engine

A single-channel direct-memory-access engine that moves a programmed number of data items between a peripheral address and a memory address. Four configuration slots sit behind a small write port: the control word, the peripheral base address, the memory base address and the item count. Setting the enable bit starts the channel. From then on the configuration is frozen. Only the enable bit can be cleared, which stops the channel.

Each item is a read beat followed by a write beat on a single-beat bus master port. No other beat is outstanding while an item is in progress. The request side of that port uses valid/ready. Once `bus_req_valid` is raised, the engine holds the address, direction, size and write data stable until `bus_req_ready` is seen high at a clock edge. The bus may stall for any number of cycles by holding ready low. The response side has no ready, because the engine always waits for a response and takes it in the cycle `bus_rsp_valid` is high. The bus must give exactly one response for each accepted request.

In peripheral-paced modes, each item waits for the peripheral's request and is closed with a one-cycle acknowledge. The engine raises one-cycle event pulses toward an interrupt block at the half-way point, on completion and on a bus error. The 2-bit priority field is exported for an external arbiter.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, every configuration slot reads back 0, `chan_en` is 0, no bus request is raised and all event outputs are low.
- R2: While the channel is enabled, writes to the address slots, to the count slot and to every control field other than enable leave their read-back values unchanged. A control write with bit 0 = 0 clears enable.
- R3: A control write with bit 0 = 1 starts the channel only when it is disabled and the count slot is non-zero. Starting copies both base addresses and the count into the running address and count registers.
- R4: Control bit 11 selects memory-to-memory. Control bit 1 selects the direction: 0 reads the peripheral address and writes the memory address, and 1 does the reverse. With bit 11 = 1, items proceed without `per_req` and `per_ack` never pulses. With bit 11 = 0, each item starts only while `per_req` is high, and ends with exactly one one-cycle `per_ack` pulse after its write response.
- R5: Control bits [6:5] give the peripheral width and bits [8:7] give the memory width, with codes 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes (11 behaves as 4 bytes). Each beat carries its side's code on `bus_size`. The written data is the read data with all bits above the source width cleared.
- R6: Control bit 3 enables peripheral address increment and bit 4 enables memory address increment. An enabled address advances by its width in bytes after each item. A disabled address stays at its base.
- R7: A raised bus request keeps valid, address and direction unchanged until accepted. Only one request is outstanding at a time.
- R8: `evt_full` pulses for one cycle after the last item. In non-circular mode the channel then clears its own enable.
- R9: `evt_half` pulses for one cycle when the remaining count first reaches the programmed count divided by two, rounded down.
- R10: With control bit 2 set, the last item reloads both base addresses and the count. The channel continues, and `evt_full` pulses on every pass.
- R11: An error response to either beat aborts the transfer. It clears enable and pulses `evt_err`, and no further request, `per_ack` or `evt_full` follows.
- R12: Control bits [10:9] appear on `chan_prio`.
- R13: Clearing enable during an item lets that item's read and write finish, after which no new request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Slot select: 0 control, 1 peripheral base, 2 memory base, 3 count |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected slot (control read-back includes live enable in bit 0) |
| chan_en | output | 1 | Channel enable state |
| chan_prio | output | 2 | Priority field for an external arbiter |
| per_req | input | 1 | Peripheral request level |
| per_ack | output | 1 | One-cycle acknowledge per completed item |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr | output | ADDR_W | Beat byte address |
| bus_size | output | 2 | Beat width code |
| bus_wdata | output | 32 | Write data |
| bus_rsp_valid | input | 1 | Response valid |
| bus_rsp_err | input | 1 | Response carries an error |
| bus_rdata | input | 32 | Read response data |
| evt_full | output | 1 | Transfer-complete pulse |
| evt_half | output | 1 | Half-way pulse |
| evt_err | output | 1 | Bus-error pulse |

## Verification
The assertions rely on the bus answering each accepted request with exactly one single-cycle response, and never answering when nothing is outstanding. They also assume the configuration port is only driven between clock edges.

The bench's bus model enforces these conditions by construction. It captures a request only when it sees valid and ready together. It then answers exactly once, one cycle later, and decides the error response from the address alone. The model can also toggle ready every cycle to exercise back-pressure. The peripheral request is driven as a level: it is held high throughout paced runs and held low only where waiting is the point of the test.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_PBASE = 2'd1,
    SEL_MBASE = 2'd2,
    SEL_COUNT = 2'd3
  } cfg_sel_e;

  // Control word bits [11:1]; bit 0 (enable) is kept separately.
  typedef struct packed {
    logic       m2m;
    logic [1:0] prio;
    logic [1:0] m_width;
    logic [1:0] p_width;
    logic       m_inc;
    logic       p_inc;
    logic       circ;
    logic       dir;
  } ctrl_t;

  localparam int CtrlBits = $bits(ctrl_t);

  typedef enum logic [2:0] {
    S_IDLE,
    S_WREQ,
    S_RD,
    S_RDW,
    S_WR,
    S_WRW,
    S_STEP
  } seq_state_e;

  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'b00:   width_bytes = 3'd1;
      2'b01:   width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] width_mask(input logic [1:0] code);
    case (code)
      2'b00:   width_mask = 32'h0000_00FF;
      2'b01:   width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              seq_busy_i,
  input  logic              seq_clear_en_i,
  output logic              en_o,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] pbase_o,
  output logic [ADDR_W-1:0] mbase_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              start_o
);

  logic              en_q;
  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] pbase_q;
  logic [ADDR_W-1:0] mbase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_ctrl;

  assign wr_ctrl = cfg_we_i && (cfg_sel_i == SEL_CTRL);
  assign start_o = wr_ctrl && !en_q && cfg_wdata_i[0] && (cnt_q != '0) && !seq_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      ctrl_q  <= '0;
      pbase_q <= '0;
      mbase_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (cfg_we_i && !en_q) begin
        case (cfg_sel_i)
          SEL_CTRL:  ctrl_q  <= ctrl_t'(cfg_wdata_i[CtrlBits:1]);
          SEL_PBASE: pbase_q <= cfg_wdata_i[ADDR_W-1:0];
          SEL_MBASE: mbase_q <= cfg_wdata_i[ADDR_W-1:0];
          default:   cnt_q   <= cfg_wdata_i[CNT_W-1:0];
        endcase
      end
      if (seq_clear_en_i || (wr_ctrl && en_q && !cfg_wdata_i[0])) en_q <= 1'b0;
      else if (start_o) en_q <= 1'b1;
    end
  end

  always_comb begin
    case (cfg_sel_i)
      SEL_CTRL:  cfg_rdata_o = 32'({ctrl_q, en_q});
      SEL_PBASE: cfg_rdata_o = 32'(pbase_q);
      SEL_MBASE: cfg_rdata_o = 32'(mbase_q);
      default:   cfg_rdata_o = 32'(cnt_q);
    endcase
  end

  assign en_o    = en_q;
  assign ctrl_o  = ctrl_q;
  assign pbase_o = pbase_q;
  assign mbase_o = mbase_q;
  assign cnt_o   = cnt_q;

  // R2: configuration frozen while enabled
  a_r2_pbase_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(pbase_q));
  a_r2_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(cnt_q) && $stable(ctrl_q));

endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   step_i,
  input  logic                   circ_i,
  input  logic [1:0]             inc_i,     // [0] peripheral, [1] memory
  input  logic [1:0][1:0]        width_i,
  input  logic [1:0][ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]       cnt_base_i,
  output logic [1:0][ADDR_W-1:0] addr_o,
  output logic                   last_o,
  output logic                   evt_full_o,
  output logic                   evt_half_o
);

  localparam int Sides = 2;

  logic [CNT_W-1:0] remain_q;
  logic             reload;

  assign last_o = (remain_q == CNT_W'(1));
  assign reload = step_i && last_o && circ_i;

  for (genvar s = 0; s < Sides; s++) begin : g_side
    logic [ADDR_W-1:0] a_q;
    logic [ADDR_W-1:0] stride;
    assign stride = inc_i[s] ? ADDR_W'(width_bytes(width_i[s])) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                a_q <= '0;
      else if (start_i || reload) a_q <= base_i[s];
      else if (step_i)            a_q <= a_q + stride;
    end
    assign addr_o[s] = a_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q   <= '0;
      evt_full_o <= 1'b0;
      evt_half_o <= 1'b0;
    end else begin
      if (start_i || reload) remain_q <= cnt_base_i;
      else if (step_i)       remain_q <= remain_q - CNT_W'(1);
      evt_full_o <= step_i && last_o;
      evt_half_o <= step_i && ((remain_q - CNT_W'(1)) == (cnt_base_i >> 1));
    end
  end

  // R8: an item never completes with no count left
  a_r8_step_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> remain_q != '0);
  // R10: circular wrap restores the programmed count
  a_r10_reload_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o && circ_i) |=> remain_q == $past(cnt_base_i));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              m2m_i,
  input  logic              dir_i,
  input  logic              circ_i,
  input  logic [1:0]        p_width_i,
  input  logic [1:0]        m_width_i,
  input  logic              per_req_i,
  output logic              per_ack_o,
  input  logic [ADDR_W-1:0] p_addr_i,
  input  logic [ADDR_W-1:0] m_addr_i,
  input  logic              last_i,
  output logic              bus_req_valid_o,
  input  logic              bus_req_ready_i,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_size_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_rsp_valid_i,
  input  logic              bus_rsp_err_i,
  input  logic [31:0]       bus_rdata_i,
  output logic              step_o,
  output logic              clear_en_o,
  output logic              busy_o,
  output logic              evt_err_o
);

  seq_state_e        state_q, state_d;
  logic [31:0]       data_q;
  logic              abort;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [1:0]        src_w, dst_w;

  assign src_addr = dir_i ? m_addr_i : p_addr_i;
  assign dst_addr = dir_i ? p_addr_i : m_addr_i;
  assign src_w    = dir_i ? m_width_i : p_width_i;
  assign dst_w    = dir_i ? p_width_i : m_width_i;

  assign abort = ((state_q == S_RDW) || (state_q == S_WRW)) && bus_rsp_valid_i && bus_rsp_err_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (en_i) state_d = S_WREQ;
      S_WREQ: begin
        if (!en_i)                     state_d = S_IDLE;
        else if (m2m_i || per_req_i)   state_d = S_RD;
      end
      S_RD:   if (bus_req_ready_i) state_d = S_RDW;
      S_RDW:  if (bus_rsp_valid_i) state_d = bus_rsp_err_i ? S_IDLE : S_WR;
      S_WR:   if (bus_req_ready_i) state_d = S_WRW;
      S_WRW:  if (bus_rsp_valid_i) state_d = bus_rsp_err_i ? S_IDLE : S_STEP;
      S_STEP: state_d = (en_i && !(last_i && !circ_i)) ? S_WREQ : S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      data_q    <= '0;
      evt_err_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      evt_err_o <= abort;
      if ((state_q == S_RDW) && bus_rsp_valid_i && !bus_rsp_err_i)
        data_q <= bus_rdata_i & width_mask(src_w);
    end
  end

  assign bus_req_valid_o = (state_q == S_RD) || (state_q == S_WR);
  assign bus_we_o        = (state_q == S_WR);
  assign bus_addr_o      = bus_we_o ? dst_addr : src_addr;
  assign bus_size_o      = bus_we_o ? dst_w : src_w;
  assign bus_wdata_o     = data_q;
  assign step_o          = (state_q == S_STEP);
  assign per_ack_o       = step_o && !m2m_i;
  assign clear_en_o      = abort || (step_o && last_i && !circ_i);
  assign busy_o          = (state_q != S_IDLE);

  // R7: request held until accepted
  a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_valid_o && !bus_req_ready_i) |=>
      (bus_req_valid_o && $stable(bus_addr_o) && $stable(bus_we_o)));
  // R4: acknowledge is a single-cycle pulse
  a_r4_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_ack_o |=> !per_ack_o);
  // R11: nothing is requested in the cycle the error is reported
  a_r11_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_err_o |-> !bus_req_valid_o && !per_ack_o);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              chan_en,
  output logic [1:0]        chan_prio,
  input  logic              per_req,
  output logic              per_ack,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [31:0]       bus_wdata,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_err,
  input  logic [31:0]       bus_rdata,
  output logic              evt_full,
  output logic              evt_half,
  output logic              evt_err
);

  ctrl_t                  ctrl;
  logic [ADDR_W-1:0]      pbase, mbase;
  logic [CNT_W-1:0]       cnt_base;
  logic                   start, step, last, clear_en, busy;
  logic [1:0][ADDR_W-1:0] run_addr;

  dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .cfg_we_i       (cfg_we),
    .cfg_sel_i      (cfg_sel),
    .cfg_wdata_i    (cfg_wdata),
    .cfg_rdata_o    (cfg_rdata),
    .seq_busy_i     (busy),
    .seq_clear_en_i (clear_en),
    .en_o           (chan_en),
    .ctrl_o         (ctrl),
    .pbase_o        (pbase),
    .mbase_o        (mbase),
    .cnt_o          (cnt_base),
    .start_o        (start)
  );

  dma_chan_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .step_i     (step),
    .circ_i     (ctrl.circ),
    .inc_i      ({ctrl.m_inc, ctrl.p_inc}),
    .width_i    ({ctrl.m_width, ctrl.p_width}),
    .base_i     ({mbase, pbase}),
    .cnt_base_i (cnt_base),
    .addr_o     (run_addr),
    .last_o     (last),
    .evt_full_o (evt_full),
    .evt_half_o (evt_half)
  );

  dma_chan_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .en_i            (chan_en),
    .m2m_i           (ctrl.m2m),
    .dir_i           (ctrl.dir),
    .circ_i          (ctrl.circ),
    .p_width_i       (ctrl.p_width),
    .m_width_i       (ctrl.m_width),
    .per_req_i       (per_req),
    .per_ack_o       (per_ack),
    .p_addr_i        (run_addr[0]),
    .m_addr_i        (run_addr[1]),
    .last_i          (last),
    .bus_req_valid_o (bus_req_valid),
    .bus_req_ready_i (bus_req_ready),
    .bus_we_o        (bus_we),
    .bus_addr_o      (bus_addr),
    .bus_size_o      (bus_size),
    .bus_wdata_o     (bus_wdata),
    .bus_rsp_valid_i (bus_rsp_valid),
    .bus_rsp_err_i   (bus_rsp_err),
    .bus_rdata_i     (bus_rdata),
    .step_o          (step),
    .clear_en_o      (clear_en),
    .busy_o          (busy),
    .evt_err_o       (evt_err)
  );

  assign chan_prio = ctrl.prio;

  // R11: an error report always leaves the channel disabled
  a_r11_err_disables: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |-> !chan_en);

endmodule

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LOG_DEPTH  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        chan_en;
  logic [1:0]  chan_prio;
  logic        per_req = 1'b0;
  logic        per_ack;
  logic        bus_req_valid;
  logic        bus_req_ready = 1'b1;
  logic        bus_we;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic        bus_rsp_valid = 1'b0;
  logic        bus_rsp_err = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        evt_full, evt_half, evt_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .chan_en(chan_en), .chan_prio(chan_prio), .per_req(per_req),
    .per_ack(per_ack), .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err), .bus_rdata(bus_rdata),
    .evt_full(evt_full), .evt_half(evt_half), .evt_err(evt_err)
  );

  int checks = 0;
  int failures = 0;
  bit stall = 1'b0;
  bit finished = 1'b0;

  // observation logs
  logic [31:0] wa [LOG_DEPTH];
  logic [31:0] wd [LOG_DEPTH];
  logic [1:0]  ws [LOG_DEPTH];
  int wr_n, rd_n, ack_n, full_n, half_n, err_n, half_at, hold_bad;
  bit          pend_hold = 1'b0;
  logic [31:0] pend_addr = '0;

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return a ^ 32'hC3A5_0F96;
  endfunction

  function automatic logic [31:0] wmask(input logic [1:0] w);
    return (w == 2'd0) ? 32'hFF : (w == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic int wbytes(input logic [1:0] w);
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit en, input bit dir, input bit circ,
      input bit pinc, input bit minc, input logic [1:0] pw, input logic [1:0] mw,
      input logic [1:0] prio, input bit m2m);
    return {20'b0, m2m, prio, mw, pw, minc, pinc, circ, dir, en};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    wr_n = 0; rd_n = 0; ack_n = 0; full_n = 0; half_n = 0; err_n = 0;
    half_at = -1; hold_bad = 0;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [31:0] data);
    @(negedge clk);
    cfg_sel = sel;
    #1;
    data = cfg_rdata;
  endtask

  // monitor: everything sampled at the falling edge
  initial forever begin
    @(negedge clk);
    if (pend_hold && !(bus_req_valid && bus_addr == pend_addr)) hold_bad++;
    pend_hold = bus_req_valid && !bus_req_ready;
    pend_addr = bus_addr;
    if (bus_req_valid && bus_req_ready) begin
      if (bus_we) begin
        if (wr_n < LOG_DEPTH) begin
          wa[wr_n] = bus_addr; wd[wr_n] = bus_wdata; ws[wr_n] = bus_size;
        end
        wr_n++;
      end else rd_n++;
    end
    if (per_ack) ack_n++;
    if (evt_full) full_n++;
    if (evt_err) err_n++;
    if (evt_half) begin
      half_n++;
      if (half_at < 0) half_at = wr_n;
    end
  end

  // bus responder: one response, one cycle after each accept; error in 0xE region
  initial forever begin
    @(negedge clk);
    if (bus_req_valid && bus_req_ready) begin
      logic [31:0] a;
      a = bus_addr;
      @(posedge clk);
      #1;
      bus_rsp_valid = 1'b1;
      bus_rsp_err   = (a[31:28] == 4'hE);
      bus_rdata     = mem_val(a);
      @(posedge clk);
      #1;
      bus_rsp_valid = 1'b0;
      bus_rsp_err   = 1'b0;
    end
  end

  // ready driver: alternates when stalling
  initial forever begin
    @(posedge clk);
    #1;
    bus_req_ready = stall ? ~bus_req_ready : 1'b1;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  typedef struct packed {
    logic        m2m;
    logic        dir;
    logic        pinc;
    logic        minc;
    logic [1:0]  pw;
    logic [1:0]  mw;
    logic        stall;
    logic [31:0] pa;
    logic [31:0] ma;
    logic [15:0] cnt;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd2, 1'b0, 32'h4000_0010, 32'h2000_0000, 16'd4},
    '{1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1, 32'h4000_0020, 32'h2000_0100, 16'd5},
    '{1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 2'd2, 1'b0, 32'h1000_0000, 32'h2000_0200, 16'd6},
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 2'd0, 1'b1, 32'h3000_0000, 32'h2000_0300, 16'd3},
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 2'd1, 1'b0, 32'h4000_0040, 32'h2000_0400, 16'd1},
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 2'd1, 1'b0, 32'h4000_0080, 32'h2000_0500, 16'd7}
  };

  task automatic run_vec(input int k);
    vec_t v;
    int bad_addr, bad_data, bad_size;
    logic [31:0] sb, db;
    logic [1:0] sw, dw;
    bit si, di;
    v = VECS[k];
    clear_logs();
    stall = v.stall;
    per_req = 1'b1;
    cfg_write(2'd1, v.pa);
    cfg_write(2'd2, v.ma);
    cfg_write(2'd3, {16'b0, v.cnt});
    cfg_write(2'd0, mk_ctrl(1'b1, v.dir, 1'b0, v.pinc, v.minc, v.pw, v.mw, 2'd0, v.m2m));
    for (int c = 0; c < 4000 && chan_en; c++) @(negedge clk);
    repeat (4) @(negedge clk);
    stall = 1'b0;
    sb = v.dir ? v.ma : v.pa;  db = v.dir ? v.pa : v.ma;
    sw = v.dir ? v.mw : v.pw;  dw = v.dir ? v.pw : v.mw;
    si = v.dir ? v.minc : v.pinc;  di = v.dir ? v.pinc : v.minc;
    bad_addr = 0; bad_data = 0; bad_size = 0;
    for (int i = 0; i < int'(v.cnt) && i < wr_n; i++) begin
      logic [31:0] sa, da;
      sa = sb + (si ? 32'(i * wbytes(sw)) : 32'd0);
      da = db + (di ? 32'(i * wbytes(dw)) : 32'd0);
      if (wa[i] != da) bad_addr++;
      if (wd[i] != (mem_val(sa) & wmask(sw))) bad_data++;
      if (ws[i] != dw) bad_size++;
    end
    check(wr_n == int'(v.cnt), "R4", "write beat count", 32'(wr_n), 32'(v.cnt));
    check(bad_addr == 0, "R6", "address sequence mismatches", 32'(bad_addr), 32'd0);
    check(bad_data == 0, "R5", "masked data mismatches", 32'(bad_data), 32'd0);
    check(bad_size == 0, "R5", "write size mismatches", 32'(bad_size), 32'd0);
    check(full_n == 1, "R8", "full events", 32'(full_n), 32'd1);
    check(half_at == int'(v.cnt) - int'(v.cnt) / 2, "R9", "items done at half event",
          32'(half_at), 32'(int'(v.cnt) - int'(v.cnt) / 2));
    check(ack_n == (v.m2m ? 0 : int'(v.cnt)), "R4", "acknowledge count",
          32'(ack_n), v.m2m ? 32'd0 : 32'(v.cnt));
    check(!chan_en, "R8", "enable cleared on completion", 32'(chan_en), 32'd0);
    check(hold_bad == 0, "R7", "request dropped or changed before accept", 32'(hold_bad), 32'd0);
  endtask

  initial begin
    logic [31:0] rd;
    int w_snap;
    clear_logs();
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(!chan_en, "R1", "enable at reset", 32'(chan_en), 32'd0);
    check(!bus_req_valid, "R1", "bus idle at reset", 32'(bus_req_valid), 32'd0);
    check(!evt_full && !evt_half && !evt_err, "R1", "events at reset",
          {29'd0, evt_full, evt_half, evt_err}, 32'd0);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) begin
      cfg_read(2'(s), rd);
      check(rd == 32'd0, "R1", "slot read-back after reset", rd, 32'd0);
    end

    // vector table walk
    for (int k = 0; k < NVEC; k++) run_vec(k);

    // R12 priority export
    cfg_write(2'd0, mk_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd2, 1'b0));
    @(negedge clk);
    check(chan_prio == 2'd2, "R12", "priority export", 32'(chan_prio), 32'd2);

    // R3 zero count: enable refused
    clear_logs();
    cfg_write(2'd3, 32'd0);
    cfg_write(2'd0, mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 1'b1));
    repeat (10) @(negedge clk);
    check(!chan_en, "R3", "enable with zero count", 32'(chan_en), 32'd0);
    check(rd_n == 0, "R3", "no beats with zero count", 32'(rd_n), 32'd0);

    // R4 waiting for peripheral request, R2 frozen configuration
    clear_logs();
    per_req = 1'b0;
    cfg_write(2'd1, 32'h4000_1000);
    cfg_write(2'd3, 32'd4);
    cfg_write(2'd0, mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd2, 2'd0, 1'b0));
    repeat (20) @(negedge clk);
    check(rd_n == 0 && chan_en, "R4", "no beat without peripheral request", 32'(rd_n), 32'd0);
    cfg_write(2'd1, 32'h5555_5555);
    cfg_read(2'd1, rd);
    check(rd == 32'h4000_1000, "R2", "peripheral base write while enabled", rd, 32'h4000_1000);
    cfg_write(2'd3, 32'd9);
    cfg_read(2'd3, rd);
    check(rd == 32'd4, "R2", "count write while enabled", rd, 32'd4);
    cfg_write(2'd0, mk_ctrl(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 2'd1, 2'd3, 1'b1));
    cfg_read(2'd0, rd);
    check(rd == mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd2, 2'd0, 1'b0), "R2",
          "control write while enabled", rd,
          mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd2, 2'd0, 1'b0));
    check(chan_prio == 2'd0, "R2", "priority unchanged while enabled", 32'(chan_prio), 32'd0);
    cfg_write(2'd0, 32'd0);
    @(negedge clk);
    check(!chan_en, "R2", "enable cleared by software", 32'(chan_en), 32'd0);
    per_req = 1'b1;
    repeat (10) @(negedge clk);
    check(rd_n == 0, "R13", "no beat after disable while waiting", 32'(rd_n), 32'd0);

    // R11 error on the read beat
    clear_logs();
    cfg_write(2'd1, 32'hE000_0000);
    cfg_write(2'd2, 32'h2000_0700);
    cfg_write(2'd3, 32'd4);
    cfg_write(2'd0, mk_ctrl(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 2'd2, 2'd0, 1'b1));
    repeat (30) @(negedge clk);
    check(err_n == 1, "R11", "error event on read", 32'(err_n), 32'd1);
    check(!chan_en, "R11", "enable cleared on error", 32'(chan_en), 32'd0);
    check(wr_n == 0 && rd_n == 1, "R11", "beats after read error", 32'(wr_n + rd_n), 32'd1);
    check(full_n == 0, "R11", "no full event after error", 32'(full_n), 32'd0);

    // R11 error on the write beat, peripheral-paced
    clear_logs();
    cfg_write(2'd1, 32'h4000_0000);
    cfg_write(2'd2, 32'hE000_0100);
    cfg_write(2'd0, mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd2, 2'd0, 1'b0));
    repeat (30) @(negedge clk);
    check(err_n == 1 && wr_n == 1, "R11", "write error aborts after one beat",
          32'(wr_n), 32'd1);
    check(ack_n == 0, "R11", "no acknowledge after error", 32'(ack_n), 32'd0);

    // R10 circular reload, then R13 disable at item boundary
    clear_logs();
    cfg_write(2'd1, 32'h3000_0600);
    cfg_write(2'd2, 32'h2000_0600);
    cfg_write(2'd3, 32'd3);
    cfg_write(2'd0, mk_ctrl(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 2'd2, 2'd0, 1'b1));
    for (int c = 0; c < 2000 && wr_n < 7; c++) @(negedge clk);
    cfg_write(2'd0, mk_ctrl(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 2'd2, 2'd0, 1'b1));
    repeat (10) @(negedge clk);
    w_snap = wr_n;
    check(wa[3] == 32'h3000_0600, "R10", "address reloaded after wrap", wa[3], 32'h3000_0600);
    check(wa[4] == 32'h3000_0604, "R10", "address advances after wrap", wa[4], 32'h3000_0604);
    check(wd[3] == mem_val(32'h2000_0600), "R10", "source reloaded after wrap",
          wd[3], mem_val(32'h2000_0600));
    check(full_n >= 2, "R10", "full event on each pass", 32'(full_n), 32'd2);
    check(half_n >= 2, "R9", "half event on each pass", 32'(half_n), 32'd2);
    check(!chan_en, "R13", "enable after software disable", 32'(chan_en), 32'd0);
    repeat (20) @(negedge clk);
    check(wr_n == w_snap && !bus_req_valid, "R13", "no beats after disable",
          32'(wr_n), 32'(w_snap));
    check(rd_n == wr_n, "R13", "item in flight completed", 32'(wr_n), 32'(rd_n));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule